// File: doc/BRIEF.md
# Two-Wire Feature Register Slave

This block is the serial control port of a video sharpness processor. It sits on a two-wire (I2C) bus as a slave and holds five write-only setting registers: a mode register and four 6-bit feature levels (peaking, steepness, coring and line width). Three read-only result registers sit beside them: a status byte and two converter results. SCL and SDA are sampled by the system clock. The block pulls SDA low through a single open-drain enable. Filtering of the bus lines and the pad itself lie outside the block.

A write begins with a subaddress byte. Each following data byte then lands in the next setting register. A read never takes a subaddress: it always starts with the status byte and steps forward byte by byte. The status byte carries a latched supply-loss flag, which clears once the master has answered the status byte, and a fixed 3-bit identity code. A bus-control bit in the mode register decides where the effective feature settings come from: the external pin-derived values or the written registers. This bit is clear after reset, so the pins are in charge until software takes over.

Top module: `fx_ctl_slave`

## Requirements
- R1: The 7-bit slave address is {addr_sel_i, 1, addr_sel_i, 0, 0, 0, 0}. With addr_sel_i low the write byte is 40h and the read byte 41h. With it high they are E0h and E1h. Any other address byte is not acknowledged, and the transfer that follows changes nothing.
- R2: In a write, the first byte after the address is the subaddress. Each later data byte goes to the register at the current subaddress, and the subaddress then advances by one. A transfer may start at any subaddress.
- R3: Subaddress 00 is the mode register: bit 3 selects the wide filter, bit 2 the double line rate, bit 1 the high amplitude range, and bit 0 is the bus-control bit. Bits 7 to 4 are ignored. Subaddresses 01 to 04 hold peaking, steepness, coring and line width in bits 5 to 0, and bits 7 to 6 are ignored.
- R4: A data byte at a subaddress of 05 or above is acknowledged and discarded. The subaddress never wraps back into range.
- R5: A read always begins at output register 00, whatever subaddress was written before. It then returns status, converter 0 and converter 1 in that order.
- R6: The status byte is {0000, ID[2:0], flag}. ID is a parameter whose default is 000.
- R7: Each converter byte is {0, valid, code[5:0]}, taken from that converter's inputs.
- R8: Read bytes past output register 02 are 00h.
- R9: The supply-loss flag is 1 after reset and is set by a pwr_lost_i pulse. It clears when the master's acknowledge bit (ACK or NACK) for the status byte is received. A set in the same cycle wins.
- R10: While the bus-control bit is 0 (its reset value), the effective settings follow the pin inputs. While it is 1, they follow the registers.
- R11: The slave pulls SDA only in the acknowledge slot of its own address and of the bytes it receives, and for 0 bits of the bytes it sends. After a NACK from the master it releases SDA and sends nothing more.
- R12: A START, including a repeated START, begins a new address phase from any state. A STOP returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Address strap |
| pwr_lost_i | input | 1 | Supply interruption pulse |
| conv0_code_i | input | 6 | Converter 0 result |
| conv0_ok_i | input | 1 | Converter 0 result valid |
| conv1_code_i | input | 6 | Converter 1 result |
| conv1_ok_i | input | 1 | Converter 1 result valid |
| pin_peak_i | input | 6 | Pin-derived peaking level |
| pin_steep_i | input | 6 | Pin-derived steepness level |
| pin_core_i | input | 6 | Pin-derived coring level |
| pin_width_i | input | 6 | Pin-derived line width level |
| pin_wide_i | input | 1 | Pin-derived wide filter select |
| pin_dbl_i | input | 1 | Pin-derived double line rate select |
| pin_amp_i | input | 1 | Pin-derived high amplitude select |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| bus_ctl_o | output | 1 | Bus-control bit |
| peak_o | output | 6 | Effective peaking level |
| steep_o | output | 6 | Effective steepness level |
| core_o | output | 6 | Effective coring level |
| width_o | output | 6 | Effective line width level |
| wide_o | output | 1 | Effective wide filter select |
| dbl_o | output | 1 | Effective double line rate select |
| amp_o | output | 1 | Effective high amplitude select |

## Verification
The bench writes a full register burst whose bytes carry set bits in the ignored upper positions. It follows this with a single direct write in the middle of the map and a write above the map. Between them, these show auto-increment, masking and discard apart. Reads are issued straight after reset, after a pwr_lost_i pulse, after a subaddress write with a repeated START, and with a NACK on the first byte. This separates "starts at status" from "continues from the subaddress" and "clears on read" from "clears on ACK only". The strap is flipped so that each address is tried both as a match and as a miss. The pin inputs are changed while the bus-control bit is 0 and while it is 1, to show which source drives the outputs.

// File: rtl/fx_ctl_pkg.sv
package fx_ctl_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SUB, ST_WDATA, ST_ACK, ST_READ, ST_MACK, ST_SKIP
  } link_state_t;

  // slave address pattern: strap, 1, strap, 0000
  function automatic logic [ADDR_W-1:0] slave_addr(input logic strap);
    return {strap, 1'b1, strap, 4'b0000};
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic [2:0] id, input logic flag);
    return {4'b0000, id, flag};
  endfunction

  function automatic logic [BYTE_W-1:0] conv_byte(input logic ok, input logic [5:0] code);
    return {1'b0, ok, code};
  endfunction
endpackage

// File: rtl/fx_link_engine.sv
module fx_link_engine
  import fx_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_pull_o,
  output logic              addr_hit_o,
  output logic              addr_rd_o,
  output logic              sub_ev_o,
  output logic              wdat_ev_o,
  output logic              rd_done_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  localparam logic [3:0] FULL = 4'(BYTE_W);

  logic scl_s1, scl_s2, scl_p;
  logic sda_s1, sda_s2, sda_p;
  link_state_t state, ack_to;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg;
  logic              mack_ok;

  // named bus events
  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s2 & ~scl_p;
  assign scl_fall = ~scl_s2 & scl_p;
  assign start_c  = scl_s2 & scl_p & sda_p & ~sda_s2;
  assign stop_c   = scl_s2 & scl_p & ~sda_p & sda_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s1 <= 1'b1; scl_s2 <= 1'b1; scl_p <= 1'b1;
      sda_s1 <= 1'b1; sda_s2 <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s1 <= scl_i;  scl_s2 <= scl_s1; scl_p <= scl_s2;
      sda_s1 <= sda_i;  sda_s2 <= sda_s1; sda_p <= sda_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ack_to     <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      mack_ok    <= 1'b0;
      sda_pull_o <= 1'b0;
      addr_hit_o <= 1'b0;
      addr_rd_o  <= 1'b0;
      sub_ev_o   <= 1'b0;
      wdat_ev_o  <= 1'b0;
      rd_done_o  <= 1'b0;
      rx_byte_o  <= '0;
    end else begin
      addr_hit_o <= 1'b0;
      sub_ev_o   <= 1'b0;
      wdat_ev_o  <= 1'b0;
      rd_done_o  <= 1'b0;
      if (start_c) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_c) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise && cnt < FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s2};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == FULL) begin
              cnt       <= '0;
              rx_byte_o <= shreg;
              if (state == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == own_addr) begin
                  sda_pull_o <= 1'b1;
                  state      <= ST_ACK;
                  ack_to     <= shreg[0] ? ST_READ : ST_SUB;
                  addr_hit_o <= 1'b1;
                  addr_rd_o  <= shreg[0];
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                sda_pull_o <= 1'b1;
                state      <= ST_ACK;
                ack_to     <= ST_WDATA;
                if (state == ST_SUB) sub_ev_o <= 1'b1;
                else                 wdat_ev_o <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (ack_to == ST_READ) begin
                sda_pull_o <= ~tx_byte[BYTE_W-1];
                shreg      <= {tx_byte[BYTE_W-2:0], 1'b0};
                cnt        <= 4'd1;
                state      <= ST_READ;
              end else begin
                sda_pull_o <= 1'b0;
                cnt        <= '0;
                state      <= ack_to;
              end
            end
          end
          ST_READ: begin
            if (scl_fall) begin
              if (cnt == FULL) begin
                sda_pull_o <= 1'b0;
                state      <= ST_MACK;
              end else begin
                sda_pull_o <= ~shreg[BYTE_W-1];
                shreg      <= {shreg[BYTE_W-2:0], 1'b0};
                cnt        <= cnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok   <= ~sda_s2;
              rd_done_o <= 1'b1;
            end else if (scl_fall) begin
              if (mack_ok) begin
                sda_pull_o <= ~tx_byte[BYTE_W-1];
                shreg      <= {tx_byte[BYTE_W-2:0], 1'b0};
                cnt        <= 4'd1;
                state      <= ST_READ;
              end else begin
                sda_pull_o <= 1'b0;
                state      <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  pull_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (state == ST_ACK || state == ST_READ));
  // R12
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == ST_ADDR && !sda_pull_o));
  // R12
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && !start_c) |=> (state == ST_IDLE));
  // R11
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MACK && scl_fall && !mack_ok && !start_c && !stop_c) |=> (!sda_pull_o && state == ST_SKIP));
endmodule

// File: rtl/fx_reg_file.sv
module fx_reg_file
  import fx_ctl_pkg::*;
#(
  parameter int         LVL_W   = 6,
  parameter int         NUM_IN  = 5,
  parameter int         NUM_OUT = 3,
  parameter logic [2:0] ID_CODE = 3'b000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        addr_hit,
  input  logic                        addr_rd,
  input  logic                        sub_ev,
  input  logic                        wdat_ev,
  input  logic                        rd_done,
  input  logic [BYTE_W-1:0]           rx_byte,
  input  logic                        pwr_lost,
  input  logic [LVL_W-1:0]            c0_code,
  input  logic                        c0_ok,
  input  logic [LVL_W-1:0]            c1_code,
  input  logic                        c1_ok,
  output logic [BYTE_W-1:0]           tx_byte,
  output logic [3:0]                  mode_q,
  output logic [NUM_IN-2:0][LVL_W-1:0] lvl_q
);
  localparam int         RD_W   = $clog2(NUM_OUT + 1);
  localparam logic [BYTE_W-1:0] IN_LIM = BYTE_W'(NUM_IN);
  localparam logic [RD_W-1:0]   RD_LIM = RD_W'(NUM_OUT);

  logic [BYTE_W-1:0] wptr;
  logic [RD_W-1:0]   rptr;
  logic              flag_q;
  logic [NUM_IN-1:0] wr_en;
  logic              status_ack;   // master answered the status byte
  logic              discard_wr;   // data byte past the map

  assign status_ack = rd_done && (rptr == '0);
  assign discard_wr = wdat_ev && (wptr >= IN_LIM);

  always_comb begin
    for (int i = 0; i < NUM_IN; i++)
      wr_en[i] = wdat_ev && (wptr == BYTE_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
    end else if (sub_ev) begin
      wptr <= rx_byte;
    end else if (wdat_ev && wptr != '1) begin
      wptr <= wptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= '0;
    else if (wr_en[0])    mode_q <= rx_byte[3:0];
  end

  for (genvar g = 0; g < NUM_IN - 1; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             lvl_q[g] <= '0;
      else if (wr_en[g + 1])  lvl_q[g] <= rx_byte[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rptr <= '0;
    else if (addr_hit && addr_rd)      rptr <= '0;
    else if (rd_done && rptr < RD_LIM) rptr <= rptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b1;
    else if (pwr_lost)   flag_q <= 1'b1;
    else if (status_ack) flag_q <= 1'b0;
  end

  always_comb begin
    case (rptr)
      RD_W'(0): tx_byte = status_byte(ID_CODE, flag_q);
      RD_W'(1): tx_byte = conv_byte(c0_ok, 6'(c0_code));
      RD_W'(2): tx_byte = conv_byte(c1_ok, 6'(c1_code));
      default:  tx_byte = '0;
    endcase
  end

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_en));
  // R4
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discard_wr |=> ($stable(mode_q) && $stable(lvl_q)));
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n) pwr_lost |=> flag_q);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(status_ack));
  // R8
  rptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) rptr <= RD_LIM);
endmodule

// File: rtl/fx_feature_sel.sv
module fx_feature_sel #(
  parameter int LVL_W = 6,
  parameter int NLVL  = 4,
  parameter int NMODE = 3
) (
  input  logic                       sel_bus,
  input  logic [NLVL-1:0][LVL_W-1:0] reg_lvl,
  input  logic [NLVL-1:0][LVL_W-1:0] pin_lvl,
  input  logic [NMODE-1:0]           reg_mode,
  input  logic [NMODE-1:0]           pin_mode,
  output logic [NLVL-1:0][LVL_W-1:0] eff_lvl,
  output logic [NMODE-1:0]           eff_mode
);
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign eff_lvl[g] = sel_bus ? reg_lvl[g] : pin_lvl[g];
  end
  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    assign eff_mode[m] = sel_bus ? reg_mode[m] : pin_mode[m];
  end
endmodule

// File: rtl/fx_ctl_slave.sv
module fx_ctl_slave
  import fx_ctl_pkg::*;
#(
  parameter int         LVL_W   = 6,
  parameter int         NUM_IN  = 5,
  parameter int         NUM_OUT = 3,
  parameter logic [2:0] ID_CODE = 3'b000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_sel_i,
  input  logic             pwr_lost_i,
  input  logic [LVL_W-1:0] conv0_code_i,
  input  logic             conv0_ok_i,
  input  logic [LVL_W-1:0] conv1_code_i,
  input  logic             conv1_ok_i,
  input  logic [LVL_W-1:0] pin_peak_i,
  input  logic [LVL_W-1:0] pin_steep_i,
  input  logic [LVL_W-1:0] pin_core_i,
  input  logic [LVL_W-1:0] pin_width_i,
  input  logic             pin_wide_i,
  input  logic             pin_dbl_i,
  input  logic             pin_amp_i,
  output logic             sda_pull_o,
  output logic             bus_ctl_o,
  output logic [LVL_W-1:0] peak_o,
  output logic [LVL_W-1:0] steep_o,
  output logic [LVL_W-1:0] core_o,
  output logic [LVL_W-1:0] width_o,
  output logic             wide_o,
  output logic             dbl_o,
  output logic             amp_o
);
  localparam int NLVL = NUM_IN - 1;

  logic              addr_hit, addr_rd, sub_ev, wdat_ev, rd_done;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [3:0]        mode_q;
  logic [NLVL-1:0][LVL_W-1:0] lvl_q, pin_lvl, eff_lvl;
  logic [2:0]        eff_mode;

  fx_link_engine u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .own_addr   (slave_addr(addr_sel_i)),
    .tx_byte    (tx_byte),
    .sda_pull_o (sda_pull_o),
    .addr_hit_o (addr_hit),
    .addr_rd_o  (addr_rd),
    .sub_ev_o   (sub_ev),
    .wdat_ev_o  (wdat_ev),
    .rd_done_o  (rd_done),
    .rx_byte_o  (rx_byte)
  );

  fx_reg_file #(
    .LVL_W(LVL_W), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .ID_CODE(ID_CODE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_hit (addr_hit),
    .addr_rd  (addr_rd),
    .sub_ev   (sub_ev),
    .wdat_ev  (wdat_ev),
    .rd_done  (rd_done),
    .rx_byte  (rx_byte),
    .pwr_lost (pwr_lost_i),
    .c0_code  (conv0_code_i),
    .c0_ok    (conv0_ok_i),
    .c1_code  (conv1_code_i),
    .c1_ok    (conv1_ok_i),
    .tx_byte  (tx_byte),
    .mode_q   (mode_q),
    .lvl_q    (lvl_q)
  );

  assign pin_lvl = {pin_width_i, pin_core_i, pin_steep_i, pin_peak_i};

  fx_feature_sel #(.LVL_W(LVL_W), .NLVL(NLVL), .NMODE(3)) u_sel (
    .sel_bus  (mode_q[0]),
    .reg_lvl  (lvl_q),
    .pin_lvl  (pin_lvl),
    .reg_mode (mode_q[3:1]),
    .pin_mode ({pin_wide_i, pin_dbl_i, pin_amp_i}),
    .eff_lvl  (eff_lvl),
    .eff_mode (eff_mode)
  );

  assign bus_ctl_o = mode_q[0];
  assign peak_o    = eff_lvl[0];
  assign steep_o   = eff_lvl[1];
  assign core_o    = eff_lvl[2];
  assign width_o   = eff_lvl[3];
  assign amp_o     = eff_mode[0];
  assign dbl_o     = eff_mode[1];
  assign wide_o    = eff_mode[2];

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ctl_o && $past(bus_ctl_o) && !wdat_ev && !$past(wdat_ev)) |-> $stable(peak_o));
endmodule

// File: tb/fx_ctl_slave_tb.sv
module fx_ctl_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QC = 6;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic addr_sel = 1'b0, pwr_lost = 1'b0;
  logic [5:0] c0_code = 6'h2D, c1_code = 6'h12;
  logic c0_ok = 1'b1, c1_ok = 1'b0;
  logic [5:0] p_peak = 6'h11, p_steep = 6'h22, p_core = 6'h05, p_width = 6'h3C;
  logic p_wide = 1'b1, p_dbl = 1'b0, p_amp = 1'b1;
  logic sda_pull, bus_ctl, wide, dbl, amp;
  logic [5:0] peak, steep, core, width;
  wire  sda_line = m_sda & ~sda_pull;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fx_ctl_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .pwr_lost_i(pwr_lost),
    .conv0_code_i(c0_code), .conv0_ok_i(c0_ok),
    .conv1_code_i(c1_code), .conv1_ok_i(c1_ok),
    .pin_peak_i(p_peak), .pin_steep_i(p_steep), .pin_core_i(p_core), .pin_width_i(p_width),
    .pin_wide_i(p_wide), .pin_dbl_i(p_dbl), .pin_amp_i(p_amp),
    .sda_pull_o(sda_pull), .bus_ctl_o(bus_ctl),
    .peak_o(peak), .steep_o(steep), .core_o(core), .width_o(width),
    .wide_o(wide), .dbl_o(dbl), .amp_o(amp)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (QC) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); nack = sda_line; m_scl = 1'b0; wq();
  endtask

  task automatic get_byte(input logic ack_it);
    logic [7:0] b = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); m_scl = 1'b1; wq(); b = {b[6:0], sda_line}; m_scl = 1'b0;
    end
    wq(); m_sda = ack_it ? 1'b0 : 1'b1; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
    m_sda = 1'b1;
    got_q.push_back(b);
  endtask

  // driver side of the scoreboard
  task automatic want(input string tag, input logic [7:0] v);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic send(input string tag, input logic [7:0] b, input logic exp_nack);
    logic nk;
    put_byte(b, nk);
    chk(tag, {7'b0, nk}, {7'b0, exp_nack});
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e; string t;
        g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(t, g, e);
      end
    end
  end

  task automatic finish_run();
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard actual=%0d expected=0 pending reads", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset: pins in charge
    chk("R10 reset bus_ctl", {7'b0, bus_ctl}, 8'h00);
    chk("R10 reset peak follows pin", {2'b0, peak}, 8'h11);
    chk("R10 reset width follows pin", {2'b0, width}, 8'h3C);
    chk("R10 reset modes follow pins", {5'b0, wide, dbl, amp}, 8'h05);

    // R5 R6 R7 R8 R9: read four bytes after reset
    bus_start(); send("R1 addr 41h ack", 8'h41, 1'b0);
    want("R6 R9 status after reset", 8'h01);
    want("R7 conv0", 8'h6D);
    want("R7 conv1", 8'h12);
    want("R8 past end", 8'h00);
    get_byte(1'b1); get_byte(1'b1); get_byte(1'b1); get_byte(1'b0);
    chk("R11 released after NACK", {7'b0, sda_pull}, 8'h00);
    bus_stop();

    // R9 cleared by previous read
    bus_start(); send("R1 addr 41h ack", 8'h41, 1'b0);
    want("R9 flag cleared", 8'h00); get_byte(1'b0); bus_stop();

    // R9 pulse sets flag; NACK on status still clears
    @(negedge clk); pwr_lost = 1'b1; @(negedge clk); pwr_lost = 1'b0;
    bus_start(); send("R1 addr 41h ack", 8'h41, 1'b0);
    want("R9 flag set by pulse", 8'h01); get_byte(1'b0); bus_stop();
    bus_start(); send("R1 addr 41h ack", 8'h41, 1'b0);
    want("R9 flag cleared by NACK", 8'h00); get_byte(1'b0); bus_stop();

    // R1 wrong address ignored
    bus_start(); send("R1 E0h nack strap low", 8'hE0, 1'b1);
    send("R1 byte after miss", 8'h00, 1'b1);
    send("R1 byte after miss", 8'h01, 1'b1);
    bus_stop();
    chk("R1 miss left bus_ctl", {7'b0, bus_ctl}, 8'h00);

    // R2 R3 R4 burst write
    bus_start(); send("R1 addr 40h ack", 8'h40, 1'b0);
    send("R2 sub ack", 8'h00, 1'b0);
    send("R3 mode ack", 8'hFB, 1'b0);
    send("R2 peak ack", 8'hEA, 1'b0);
    send("R2 steep ack", 8'h15, 1'b0);
    send("R2 core ack", 8'h3F, 1'b0);
    send("R2 width ack", 8'h41, 1'b0);
    send("R4 extra ack", 8'h33, 1'b0);
    send("R4 extra ack", 8'h00, 1'b0);
    bus_stop();
    chk("R10 bus_ctl set", {7'b0, bus_ctl}, 8'h01);
    chk("R3 modes wide dbl amp", {5'b0, wide, dbl, amp}, 8'h05);
    chk("R3 peak masked", {2'b0, peak}, 8'h2A);
    chk("R2 steep", {2'b0, steep}, 8'h15);
    chk("R2 core", {2'b0, core}, 8'h3F);
    chk("R3 width masked", {2'b0, width}, 8'h01);
    p_peak = 6'h07; repeat (3) @(negedge clk);
    chk("R10 bus mode ignores pin", {2'b0, peak}, 8'h2A);

    // R2 direct subaddress
    bus_start(); send("R1 addr 40h ack", 8'h40, 1'b0);
    send("R2 sub 03", 8'h03, 1'b0); send("R2 core data", 8'h07, 1'b0); bus_stop();
    chk("R2 direct core", {2'b0, core}, 8'h07);
    chk("R2 direct steep kept", {2'b0, steep}, 8'h15);

    // R4 out-of-range subaddress
    bus_start(); send("R1 addr 40h ack", 8'h40, 1'b0);
    send("R4 sub 07", 8'h07, 1'b0); send("R4 data ack", 8'h00, 1'b0);
    send("R4 data ack", 8'h00, 1'b0); bus_stop();
    chk("R4 mode kept", {7'b0, bus_ctl}, 8'h01);
    chk("R4 peak kept", {2'b0, peak}, 8'h2A);

    // R5 R12 read after subaddress via repeated start
    @(negedge clk); pwr_lost = 1'b1; @(negedge clk); pwr_lost = 1'b0;
    bus_start(); send("R1 addr 40h ack", 8'h40, 1'b0);
    send("R5 sub 02", 8'h02, 1'b0);
    bus_start(); send("R12 repeated start addr", 8'h41, 1'b0);
    want("R5 starts at status", 8'h01); want("R5 then conv0", 8'h6D);
    get_byte(1'b1); get_byte(1'b0);
    chk("R11 released after NACK", {7'b0, sda_pull}, 8'h00);
    bus_stop();

    // R1 strap high
    addr_sel = 1'b1; repeat (3) @(negedge clk);
    bus_start(); send("R1 40h nack strap high", 8'h40, 1'b1); bus_stop();
    bus_start(); send("R1 E0h ack", 8'hE0, 1'b0);
    send("R2 sub 01", 8'h01, 1'b0); send("R2 peak", 8'h30, 1'b0); bus_stop();
    chk("R1 E0h write", {2'b0, peak}, 8'h30);
    bus_start(); send("R1 E1h ack", 8'hE1, 1'b0);
    want("R6 status", 8'h00); get_byte(1'b0); bus_stop();

    // R10 back to pins
    bus_start(); send("R1 E0h ack", 8'hE0, 1'b0);
    send("R2 sub 00", 8'h00, 1'b0); send("R10 clear bus_ctl", 8'hF0, 1'b0); bus_stop();
    chk("R10 bus_ctl clear", {7'b0, bus_ctl}, 8'h00);
    chk("R10 peak from pin", {2'b0, peak}, 8'h07);
    p_peak = 6'h2F; p_dbl = 1'b1; repeat (3) @(negedge clk);
    chk("R10 peak tracks pin", {2'b0, peak}, 8'h2F);
    chk("R10 modes track pins", {5'b0, wide, dbl, amp}, 8'h07);

    done = 1'b1;
    finish_run();
  end
endmodule